// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the message-signalled interrupt capability structure of a PCI function. Software reaches it through a dword-indexed configuration port with byte enables. It keeps the enable bit, the allocated vector count, the message address, the message data, the per-vector mask and the pending bits. A message generator next to it reads the live register values from dedicated outputs and feeds pending events back in through set and clear vectors.

What the function can do is fixed at build time by three parameters: `ADDR64` adds the upper address dword, `PER_VEC_MASK` adds the mask and pending dwords, and `NUM_VEC` (1, 2, 4, 8, 16 or 32) sets the capable vector count. The structure spans 3, 4, 5 or 6 dwords, matching sizes of 0x0A, 0x0E, 0x14 and 0x18 bytes. A write that leaves MSI enabled with an allocation larger than the capable count is pulled back to the capable count. The same write also drops pending bits that lie outside the allocation. The legacy INTx request is held off for as long as MSI is enabled.

Top module: `msi_cap_regfile`

## Requirements
- R1: Synchronous reset clears enable, the allocation field, both address dwords, the data, the mask and the pending bits. Dword 0 then reads only the read-only capability bits.
- R2: Dword 0 carries the 16-bit control word in bits 31:16. Control bit 0 is enable, bits 3:1 are log2(NUM_VEC) (read-only), bits 6:4 are the allocation log2, bit 7 is the 64-bit flag and bit 8 is the mask flag (read-only). Only enable and allocation are writable, through byte lane 2.
- R3: Dword 1 is the low address, and its bits 1:0 always read zero. When ADDR64=1, dword 2 is the fully writable upper address. When ADDR64=0, address output bits 63:32 stay zero.
- R4: The 16-bit message data sits in bits 15:0 of dword 3 (64-bit) or dword 2 (32-bit). Bits 31:16 read zero.
- R5: With masking, the mask sits at dword 4 (64-bit) or dword 3 (32-bit). Only bits 0 to NUM_VEC-1 are writable.
- R6: The pending bits sit in the dword after the mask and ignore software writes. Input pend_set sets a bit and pend_clr clears it; when both hit the same bit in one cycle, set wins. No pending bit rises without a set.
- R7: If a write that hits the structure leaves enable at 1 with allocation above log2(NUM_VEC), the allocation becomes log2(NUM_VEC).
- R8: On a write that hits the structure and leaves enable at 1, pending bits at or above 2^allocation (after the clamp of R7) are cleared. This includes bits set in the same cycle.
- R9: intx_disable is 1 exactly while MSI is enabled.
- R10: A write changes only the byte lanes whose byte enable is 1. A write with all enables 0 is no hit.
- R11: Reads of dwords at or beyond the implemented size return zero, and writes there change nothing.
- R12: The register outputs show the state written at a clock edge from just after that edge. cfg_rdata is a combinational function of cfg_idx and that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 3 | Dword index within the structure |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_idx |
| pend_set | input | NUM_VEC | Set pending bits |
| pend_clr | input | NUM_VEC | Clear pending bits |
| msi_en | output | 1 | MSI enabled |
| alloc_log2 | output | 3 | log2 of allocated vectors |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | NUM_VEC | Per-vector mask |
| vec_pend | output | NUM_VEC | Per-vector pending |
| intx_disable | output | 1 | Hold off legacy INTx |

## Verification
Two actions can meet in one clock: the message generator sets a pending bit, and a software write to the structure trims the pending bits to the allocation. The bench makes them meet by asserting pend_set on vector 7 in the same cycle as a mask write, while MSI is enabled with two vectors allocated. It then expects the new bit to be gone. The same collision also occurs in the seeded random stream, where the bench model applies the set before the trim, and every output and every dword read is compared against that model after each cycle.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    typedef struct packed {
        logic       en;
        logic [2:0] mme;
    } msi_ctrl_t;

    localparam logic [31:0] ADDR_LO_WMASK = 32'hFFFF_FFFC;

    // number of dwords implemented for a given option set
    function automatic logic [2:0] dword_count(input bit a64, input bit pvm);
        return 3'd3 + (a64 ? 3'd1 : 3'd0) + (pvm ? 3'd2 : 3'd0);
    endfunction

    function automatic logic [2:0] data_dword(input bit a64);
        return a64 ? 3'd3 : 3'd2;
    endfunction

    // bit mask covering 2**lg vectors
    function automatic logic [31:0] span_of(input logic [2:0] lg);
        if (lg >= 3'd5) return 32'hFFFF_FFFF;
        return (32'd1 << (32'd1 << lg)) - 32'd1;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [31:0] merge_w(input logic [31:0] old,
                                            input logic [31:0] wd,
                                            input logic [3:0]  be,
                                            input logic [31:0] wmask);
        logic [31:0] m;
        m = lane_mask(be) & wmask;
        return (old & ~m) | (wd & m);
    endfunction

endpackage

// File: rtl/msi_ctrl_reg.sv
module msi_ctrl_reg
    import msi_cap_pkg::*;
#(
    parameter logic [2:0] MMC = 3'd3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic       wr_en_bit,
    input  logic [2:0] wr_mme,
    input  logic       cap_hit,
    output msi_ctrl_t  ctrl_q,
    output msi_ctrl_t  ctrl_nxt
);

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (ctrl_we) begin
            ctrl_nxt.en  = wr_en_bit;
            ctrl_nxt.mme = wr_mme;
        end
        // pull an oversized allocation back while enabled
        if (cap_hit && ctrl_nxt.en && (ctrl_nxt.mme > MMC))
            ctrl_nxt.mme = MMC;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_nxt;
    end

    AST_EN_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.en |-> (ctrl_q.mme <= MMC)) else $error("allocation above capable while enabled"); // R7

endmodule

// File: rtl/msi_msg_regs.sv
module msi_msg_regs
    import msi_cap_pkg::*;
#(
    parameter bit ADDR64 = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we_lo,
    input  logic        we_hi,
    input  logic        we_data,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [63:0] addr,
    output logic [15:0] data
);

    logic [31:0] lo_q;
    logic [31:0] hi_q;
    logic [15:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            data_q <= '0;
        end else begin
            if (we_lo) lo_q <= merge_w(lo_q, wdata, be, ADDR_LO_WMASK);
            if (we_data) begin
                if (be[0]) data_q[7:0]  <= wdata[7:0];
                if (be[1]) data_q[15:8] <= wdata[15:8];
            end
        end
    end

    generate
        if (ADDR64) begin : g_hi
            always_ff @(posedge clk) begin
                if (rst)        hi_q <= '0;
                else if (we_hi) hi_q <= merge_w(hi_q, wdata, be, 32'hFFFF_FFFF);
            end
        end else begin : g_no_hi
            assign hi_q = '0;
        end
    endgenerate

    assign addr = {hi_q, lo_q};
    assign data = data_q;

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we_data)) |-> $stable(data_q)) else $error("data moved without write"); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we_lo)) |-> $stable(lo_q)) else $error("address moved without write"); // R3

endmodule

// File: rtl/msi_vec_regs.sv
module msi_vec_regs
    import msi_cap_pkg::*;
#(
    parameter bit PV_MASK = 1'b1,
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_mask,
    input  logic [3:0]         be,
    input  logic [31:0]        wdata,
    input  logic [NUM_VEC-1:0] pend_set,
    input  logic [NUM_VEC-1:0] pend_clr,
    input  logic               trim,
    input  logic [2:0]         trim_log2,
    output logic [31:0]        mask_q,
    output logic [31:0]        pend_q
);

    localparam logic [2:0]  CAP_LOG2 = 3'($clog2(NUM_VEC));
    localparam logic [31:0] CAP_SPAN = span_of(CAP_LOG2);

    generate
        if (PV_MASK) begin : g_mask
            logic [31:0] set32;
            logic [31:0] clr32;
            logic [31:0] pend_n;

            assign set32 = 32'(pend_set);
            assign clr32 = 32'(pend_clr);

            always_comb begin
                pend_n = (pend_q & ~clr32) | (set32 & CAP_SPAN);
                if (trim) pend_n = pend_n & span_of(trim_log2);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q <= '0;
                    pend_q <= '0;
                end else begin
                    if (we_mask) mask_q <= merge_w(mask_q, wdata, be, CAP_SPAN);
                    pend_q <= pend_n;
                end
            end

            AST_PEND_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> ((pend_q & ~$past(pend_q) & ~$past(set32)) == 32'h0)) else $error("pending rose without set"); // R6
            AST_PEND_TRIMMED: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(trim)) |-> ((pend_q & ~span_of($past(trim_log2))) == 32'h0)) else $error("pending outside allocation"); // R8
        end else begin : g_nomask
            assign mask_q = '0;
            assign pend_q = '0;
        end
    endgenerate

endmodule

// File: rtl/msi_cap_regfile.sv
module msi_cap_regfile
    import msi_cap_pkg::*;
#(
    parameter bit ADDR64       = 1'b1,
    parameter bit PER_VEC_MASK = 1'b1,
    parameter int NUM_VEC      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         cfg_idx,
    input  logic               cfg_wr,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_VEC-1:0] pend_set,
    input  logic [NUM_VEC-1:0] pend_clr,
    output logic               msi_en,
    output logic [2:0]         alloc_log2,
    output logic [63:0]        msg_addr,
    output logic [15:0]        msg_data,
    output logic [NUM_VEC-1:0] vec_mask,
    output logic [NUM_VEC-1:0] vec_pend,
    output logic               intx_disable
);

    localparam logic [2:0] MMC     = 3'($clog2(NUM_VEC));
    localparam logic [2:0] DWN     = dword_count(ADDR64, PER_VEC_MASK);
    localparam logic [2:0] DATA_DW = data_dword(ADDR64);
    localparam logic [2:0] MASK_DW = DATA_DW + 3'd1;
    localparam logic [2:0] PEND_DW = DATA_DW + 3'd2;

    logic        in_range;
    logic        hit;
    msi_ctrl_t   ctrl_q;
    msi_ctrl_t   ctrl_nxt;
    logic [31:0] mask_q;
    logic [31:0] pend_q;
    logic [15:0] ctrl_word;

    assign in_range = (cfg_idx < DWN);
    assign hit      = cfg_wr && in_range && (cfg_be != 4'b0000);

    msi_ctrl_reg #(.MMC(MMC)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (hit && (cfg_idx == 3'd0) && cfg_be[2]),
        .wr_en_bit (cfg_wdata[16]),
        .wr_mme    (cfg_wdata[22:20]),
        .cap_hit   (hit),
        .ctrl_q    (ctrl_q),
        .ctrl_nxt  (ctrl_nxt)
    );

    msi_msg_regs #(.ADDR64(ADDR64)) i_msg (
        .clk     (clk),
        .rst     (rst),
        .we_lo   (hit && (cfg_idx == 3'd1)),
        .we_hi   (hit && ADDR64 && (cfg_idx == 3'd2)),
        .we_data (hit && (cfg_idx == DATA_DW)),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .addr    (msg_addr),
        .data    (msg_data)
    );

    msi_vec_regs #(.PV_MASK(PER_VEC_MASK), .NUM_VEC(NUM_VEC)) i_vec (
        .clk       (clk),
        .rst       (rst),
        .we_mask   (hit && (cfg_idx == MASK_DW)),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .pend_set  (pend_set),
        .pend_clr  (pend_clr),
        .trim      (hit && ctrl_nxt.en),
        .trim_log2 (ctrl_nxt.mme),
        .mask_q    (mask_q),
        .pend_q    (pend_q)
    );

    assign ctrl_word = {7'b0, 1'(PER_VEC_MASK), 1'(ADDR64), ctrl_q.mme, MMC, ctrl_q.en};

    always_comb begin
        cfg_rdata = '0;
        if (in_range) begin
            if (cfg_idx == 3'd0)                cfg_rdata = {ctrl_word, 16'h0000};
            else if (cfg_idx == 3'd1)           cfg_rdata = msg_addr[31:0];
            else if (ADDR64 && cfg_idx == 3'd2) cfg_rdata = msg_addr[63:32];
            else if (cfg_idx == DATA_DW)        cfg_rdata = {16'h0000, msg_data};
            else if (cfg_idx == MASK_DW)        cfg_rdata = mask_q;
            else if (cfg_idx == PEND_DW)        cfg_rdata = pend_q;
        end
    end

    assign msi_en       = ctrl_q.en;
    assign alloc_log2   = ctrl_q.mme;
    assign intx_disable = ctrl_q.en;
    assign vec_mask     = mask_q[NUM_VEC-1:0];
    assign vec_pend     = pend_q[NUM_VEC-1:0];

endmodule

// File: tb/test_msi_cap_regfile.sv
`timescale 1ns/100ps
module test_msi_cap_regfile;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic [2:0]  idx;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] rdata;
    logic [7:0]  pset, pclr;
    logic        en, intx;
    logic [2:0]  alloc;
    logic [63:0] addr;
    logic [15:0] data;
    logic [7:0]  mask, pend;

    msi_cap_regfile #(.ADDR64(1'b1), .PER_VEC_MASK(1'b1), .NUM_VEC(8)) i_msi_cap_regfile (
        .clk(clk), .rst(rst), .cfg_idx(idx), .cfg_wr(wr), .cfg_be(be), .cfg_wdata(wd),
        .cfg_rdata(rdata), .pend_set(pset), .pend_clr(pclr), .msi_en(en), .alloc_log2(alloc),
        .msg_addr(addr), .msg_data(data), .vec_mask(mask), .vec_pend(pend), .intx_disable(intx)
    );

    logic [2:0]  s_idx;
    logic        s_wr;
    logic [3:0]  s_be;
    logic [31:0] s_wd;
    logic [31:0] s_rdata;
    logic [0:0]  s_set, s_clr, s_mask, s_pend;
    logic        s_en, s_intx;
    logic [2:0]  s_alloc;
    logic [63:0] s_addr;
    logic [15:0] s_data;

    msi_cap_regfile #(.ADDR64(1'b0), .PER_VEC_MASK(1'b0), .NUM_VEC(1)) i_msi_cap_regfile_small (
        .clk(clk), .rst(rst), .cfg_idx(s_idx), .cfg_wr(s_wr), .cfg_be(s_be), .cfg_wdata(s_wd),
        .cfg_rdata(s_rdata), .pend_set(s_set), .pend_clr(s_clr), .msi_en(s_en), .alloc_log2(s_alloc),
        .msg_addr(s_addr), .msg_data(s_data), .vec_mask(s_mask), .vec_pend(s_pend), .intx_disable(s_intx)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench model of the default configuration (64-bit, masking, 8 vectors)
    logic        m_en;
    logic [2:0]  m_mme;
    logic [63:0] m_addr;
    logic [15:0] m_data;
    logic [7:0]  m_mask, m_pend;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] vspan(input logic [2:0] lg);
        if (lg >= 3'd3) return 8'hFF;
        return 8'((32'd1 << (32'd1 << lg)) - 32'd1);
    endfunction

    function automatic void model_reset();
        m_en = 0; m_mme = 0; m_addr = 0; m_data = 0; m_mask = 0; m_pend = 0;
    endfunction

    function automatic void model_step(input logic w, input logic [2:0] i, input logic [3:0] b,
                                       input logic [31:0] d, input logic [7:0] s, input logic [7:0] c);
        logic        h;
        logic [31:0] lm;
        h = w && (b != 4'b0) && (i < 3'd6);
        for (int k = 0; k < 4; k++) lm[8*k +: 8] = {8{b[k]}};
        if (h) begin
            case (i)
                3'd0: if (b[2]) begin m_en = d[16]; m_mme = d[22:20]; end
                3'd1: m_addr[31:0]  = (m_addr[31:0] & ~(lm & 32'hFFFF_FFFC)) | (d & lm & 32'hFFFF_FFFC);
                3'd2: m_addr[63:32] = (m_addr[63:32] & ~lm) | (d & lm);
                3'd3: m_data = (m_data & ~lm[15:0]) | (d[15:0] & lm[15:0]);
                3'd4: m_mask = (m_mask & ~lm[7:0]) | (d[7:0] & lm[7:0]);
                default: ;
            endcase
        end
        m_pend = (m_pend & ~c) | s;
        if (h && m_en && m_mme > 3'd3) m_mme = 3'd3;
        if (h && m_en) m_pend = m_pend & vspan(m_mme);
    endfunction

    function automatic logic [31:0] exp_rd(input int i);
        case (i)
            0: return {7'b0, 1'b1, 1'b1, m_mme, 3'd3, m_en, 16'h0};
            1: return m_addr[31:0];
            2: return m_addr[63:32];
            3: return {16'h0, m_data};
            4: return {24'h0, m_mask};
            5: return {24'h0, m_pend};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input int i);
        case (i)
            0: return "R2 ctrl read";
            1, 2: return "R3 address read";
            3: return "R4 data read";
            4: return "R5 mask read";
            5: return "R6 pending read";
            default: return "R11 out of range read";
        endcase
    endfunction

    task automatic step(input logic w, input logic [2:0] i, input logic [3:0] b,
                        input logic [31:0] d, input logic [7:0] s, input logic [7:0] c);
        @(negedge clk);
        wr = w; idx = i; be = b; wd = d; pset = s; pclr = c;
        @(posedge clk);
        #1;
        model_step(w, i, b, d, s, c);
        wr = 0; pset = 0; pclr = 0;
    endtask

    task automatic step_s(input logic [2:0] i, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        s_wr = 1; s_idx = i; s_be = b; s_wd = d;
        @(posedge clk);
        #1;
        s_wr = 0;
    endtask

    task automatic compare_all();
        chk("R12 msi_en", 64'(en), 64'(m_en));
        chk("R9 intx_disable", 64'(intx), 64'(m_en));
        chk("R12 alloc_log2", 64'(alloc), 64'(m_mme));
        chk("R12 msg_addr", addr, m_addr);
        chk("R12 msg_data", 64'(data), 64'(m_data));
        chk("R5 vec_mask", 64'(mask), 64'(m_mask));
        chk("R6 vec_pend", 64'(pend), 64'(m_pend));
        for (int k = 0; k < 8; k++) begin
            idx = 3'(k);
            #0.2;
            chk(rd_tag(k), 64'(rdata), 64'(exp_rd(k)));
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        rst = 1; wr = 0; idx = 0; be = 0; wd = 0; pset = 0; pclr = 0;
        s_wr = 0; s_idx = 0; s_be = 0; s_wd = 0; s_set = 0; s_clr = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;

        // R1: reset state
        compare_all();
        idx = 3'd0; #0.2;
        chk("R1 ctrl after reset", 64'(rdata), 64'h0186_0000);
        s_idx = 3'd0; #0.2;
        chk("R1 small ctrl after reset", 64'(s_rdata), 64'h0);

        // R2 / R7 / R9: write all ones to control, allocation clamps to 3
        step(1, 3'd0, 4'b1111, 32'hFFFF_FFFF, 8'h0, 8'h0);
        idx = 3'd0; #0.2;
        chk("R2 R7 ctrl clamped", 64'(rdata), 64'h01B7_0000);
        chk("R7 alloc clamped", 64'(alloc), 64'd3);
        chk("R9 intx while enabled", 64'(intx), 64'd1);

        // R8: disable, raise all pending, enable with two vectors
        step(1, 3'd0, 4'b0100, 32'h0, 8'h0, 8'h0);
        chk("R9 intx released", 64'(intx), 64'd0);
        step(0, 3'd0, 4'b0000, 32'h0, 8'hFF, 8'h0);
        chk("R6 set while disabled", 64'(pend), 64'hFF);
        step(1, 3'd0, 4'b0100, 32'h0011_0000, 8'h0, 8'h0);
        chk("R8 trim on enable", 64'(pend), 64'h03);

        // R6: software write to pending is ignored
        step(1, 3'd5, 4'b1111, 32'h0, 8'h0, 8'h0);
        chk("R6 pending write ignored", 64'(pend), 64'h03);

        // R6: set and clear on the same bit, set wins
        step(0, 3'd0, 4'b0000, 32'h0, 8'h04, 8'h05);
        chk("R6 set wins over clear", 64'(pend), 64'h06);

        // R8: set in the same cycle as a trimming write
        step(1, 3'd4, 4'b0001, 32'h0, 8'h80, 8'h0);
        chk("R8 same-cycle set trimmed", 64'(pend), 64'h02);

        // R10: only lane 0 of data written
        step(1, 3'd3, 4'b0001, 32'h1234_5678, 8'h0, 8'h0);
        chk("R10 byte lane", 64'(data), 64'h0078);

        // R11: write beyond structure
        step(1, 3'd6, 4'b1111, 32'hFFFF_FFFF, 8'h0, 8'h0);
        compare_all();

        // R5: mask upper bits read-only
        step(1, 3'd4, 4'b1111, 32'hFFFF_FFFF, 8'h0, 8'h0);
        idx = 3'd4; #0.2;
        chk("R5 mask writable width", 64'(rdata), 64'h0000_00FF);

        // R3 / R4 / R7 / R11 on the 32-bit, unmasked, single-vector build
        step_s(3'd2, 4'b1111, 32'hABCD_1234);
        chk("R4 small data", 64'(s_data), 64'h1234);
        s_idx = 3'd2; #0.2;
        chk("R4 small data read", 64'(s_rdata), 64'h0000_1234);
        step_s(3'd1, 4'b1111, 32'hFFFF_FFFF);
        chk("R3 small address", s_addr, 64'h0000_0000_FFFF_FFFC);
        step_s(3'd0, 4'b0100, 32'h0071_0000);
        chk("R7 small clamp", 64'(s_alloc), 64'd0);
        chk("R9 small intx", 64'(s_intx), 64'd1);
        s_idx = 3'd0; #0.2;
        chk("R2 small ctrl read", 64'(s_rdata), 64'h0001_0000);
        s_idx = 3'd3; #0.2;
        chk("R11 small beyond size", 64'(s_rdata), 64'h0);
        chk("R6 small no pending", 64'({s_mask, s_pend}), 64'h0);

        // seeded random stream against the model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] d;
            logic [7:0]  s, c;
            d = $urandom;
            s = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            c = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            step(($urandom % 4) != 0, 3'($urandom % 8), 4'($urandom % 16), d, s, c);
            compare_all();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule